// File: doc/BRIEF.md
# One-Time-Programmable Word Store Model

This block is a synthesizable behavioural model of a 16-bit one-time-programmable read-only memory. Its depth is set by a parameter. It is meant to act as the device under test for programmer and reader controllers. The chip enable, output enable and program strobe controls are decoded together with two flags that stand in for the high-voltage conditions: an elevated programming supply, and high voltage on address line 9. From these the model picks one of its operating modes: read, output disable, standby, program, verify, inhibit or identification.

The bidirectional data bus is split into three parts: an output-enable flag, a data-out word and a data-in word. The model drives `dout` only while `dout_oe` is high. At every other time `dout` reads zero.

A blank location holds all ones. Programming can only clear bits. A write is committed on the model clock edge at which the program strobe is first sampled high after having been sampled low in program mode.

Top module: `otp_word_store`

## Requirements
- R1: With `vpp_hi` low, `a9_hv` low, and both `chip_en_n` and `out_en_n` low, `dout_oe` is 1 and `dout` is the word stored at the addressed location, in the same cycle.
- R2: With `chip_en_n` low, `out_en_n` high and `vpp_hi` low, `dout_oe` is 0 and `dout` is 0.
- R3: With `chip_en_n` high and `vpp_hi` low (standby), `dout_oe` is 0 and `dout` is 0, whatever the other inputs are.
- R4: After reset, every location reads 0xFFFF.
- R5: A write takes place on a clock edge where `prog_n` is sampled high and the previous edge sampled program mode (`vpp_hi` 1, `chip_en_n` 0, `out_en_n` 1, `prog_n` 0), provided `vpp_hi` is still 1, `chip_en_n` still 0 and `out_en_n` still 1. If output enable goes low while the strobe is still low, no write occurs.
- R6: A write replaces the stored word with the bitwise AND of the stored word and `din`. Bits that are already 0 cannot return to 1.
- R7: With `vpp_hi` high, `chip_en_n` low, `out_en_n` low and `prog_n` high (verify), `dout_oe` is 1 and `dout` is the stored word.
- R8: With `vpp_hi` high and `chip_en_n` high (inhibit), `dout_oe` is 0 and strobe pulses leave the storage unchanged.
- R9: With `vpp_hi` low, `a9_hv` high, and `chip_en_n` and `out_en_n` low, `dout_oe` is 1 and `dout` is 0x001E when `addr[0]` is 0 and 0x00F1 when `addr[0]` is 1. The other address bits are ignored.
- R10: Only the low log2(DEPTH) address bits select a location, so `addr` and `addr + DEPTH` access the same word.
- R11: With `vpp_hi` high, `chip_en_n` low and `out_en_n` and `prog_n` both low, or `out_en_n` and `prog_n` both high, `dout_oe` is 0.
- R12: While `vpp_hi` is low, strobe pulses write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; strobe sampling and writes occur on its rising edge |
| rst_n | input | 1 | Active-low reset; blanks the array to all ones |
| chip_en_n | input | 1 | Active-low chip enable |
| out_en_n | input | 1 | Active-low output enable |
| prog_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply is elevated |
| a9_hv | input | 1 | High voltage is present on address line 9 (identification) |
| addr | input | ADDR_W (16) | Word address |
| din | input | WORD_W (16) | Word to program |
| dout | output | WORD_W (16) | Driven word; zero when not driving |
| dout_oe | output | 1 | High when the model drives the data bus |

## Verification
The hardest case to reach is a strobe whose rising edge arrives after the mode has already left program mode. The stimulus reaches it by lowering the strobe in program mode, lowering output enable while the strobe is still low, and only then raising the strobe in verify mode. The bench then reads the word back to show that it did not change. A second hard case is a strobe pulse while the supply flag is elevated but chip enable is high. A third is a full strobe pulse with the supply flag low. In both, the word that the pulse could have cleared is read back through the normal read path.

// File: rtl/otp_pkg.sv
package otp_pkg;
   typedef enum logic [2:0] {
      MD_STANDBY,
      MD_DISABLE,
      MD_READ,
      MD_IDENT,
      MD_PROGRAM,
      MD_VERIFY,
      MD_INHIBIT,
      MD_HV_IDLE
   } otp_mode_e;

   localparam logic [15:0] MAKER_WORD  = 16'h001E;
   localparam logic [15:0] DEVICE_WORD = 16'h00F1;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
   import otp_pkg::*;
(
   input  logic      chip_en_n,
   input  logic      out_en_n,
   input  logic      prog_n,
   input  logic      vpp_hi,
   input  logic      a9_hv,
   output otp_mode_e mode
);
   always_comb begin
      if (chip_en_n) begin
         mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
      end else if (vpp_hi) begin
         if (out_en_n && !prog_n)      mode = MD_PROGRAM;
         else if (!out_en_n && prog_n) mode = MD_VERIFY;
         else                          mode = MD_HV_IDLE;
      end else if (out_en_n) begin
         mode = MD_DISABLE;
      end else begin
         mode = a9_hv ? MD_IDENT : MD_READ;
      end
   end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
   parameter int DEPTH  = 64,
   parameter int WORD_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] words [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic [WORD_W-1:0] cell_q;
      logic              hit;
      assign hit = wr_en && (idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cell_q <= '1;
         else if (hit) cell_q <= cell_q & wr_data;
      end
      assign words[g] = cell_q;
   end

   assign rd_data = words[idx];
endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom #(
   parameter int              WORD_W   = 16,
   parameter logic [WORD_W-1:0] ID_LOW  = '0,
   parameter logic [WORD_W-1:0] ID_HIGH = '0
) (
   input  logic              sel,
   output logic [WORD_W-1:0] id_word
);
   assign id_word = sel ? ID_HIGH : ID_LOW;
endmodule

// File: rtl/otp_word_store.sv
module otp_word_store
   import otp_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 16,
   parameter int DEPTH  = 64,
   parameter logic [WORD_W-1:0] ID_MAKER  = WORD_W'(MAKER_WORD),
   parameter logic [WORD_W-1:0] ID_DEVICE = WORD_W'(DEVICE_WORD)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en_n,
   input  logic              out_en_n,
   input  logic              prog_n,
   input  logic              vpp_hi,
   input  logic              a9_hv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout,
   output logic              dout_oe
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("DEPTH exceeds the address range");
   end
   if (WORD_W < 1) begin : g_bad_word
      $error("WORD_W must be positive");
   end

   otp_mode_e         mode;
   logic              armed_q;
   logic              wr_en;
   logic [WORD_W-1:0] cell_word;
   logic [WORD_W-1:0] id_word;

   otp_mode_decode u_decode (
      .chip_en_n (chip_en_n),
      .out_en_n  (out_en_n),
      .prog_n    (prog_n),
      .vpp_hi    (vpp_hi),
      .a9_hv     (a9_hv),
      .mode      (mode)
   );

   // Strobe low seen in program mode arms the write; the next high sample commits it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= (mode == MD_PROGRAM);
   end

   assign wr_en = armed_q && prog_n && vpp_hi && !chip_en_n && out_en_n;

   otp_cell_array #(
      .DEPTH  (DEPTH),
      .WORD_W (WORD_W)
   ) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .idx     (addr[IDX_W-1:0]),
      .wr_data (din),
      .rd_data (cell_word)
   );

   otp_id_rom #(
      .WORD_W  (WORD_W),
      .ID_LOW  (ID_MAKER),
      .ID_HIGH (ID_DEVICE)
   ) u_id (
      .sel     (addr[0]),
      .id_word (id_word)
   );

   always_comb begin
      dout_oe = 1'b0;
      dout    = '0;
      unique case (mode)
         MD_READ, MD_VERIFY: begin
            dout_oe = 1'b1;
            dout    = cell_word;
         end
         MD_IDENT: begin
            dout_oe = 1'b1;
            dout    = id_word;
         end
         default: begin
            dout_oe = 1'b0;
            dout    = '0;
         end
      endcase
   end
endmodule

// File: rtl/otp_word_store_chk.sv
module otp_word_store_chk #(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_en_n,
   input logic              out_en_n,
   input logic              prog_n,
   input logic              vpp_hi,
   input logic              a9_hv,
   input logic [ADDR_W-1:0] addr,
   input logic [WORD_W-1:0] dout,
   input logic              dout_oe,
   input logic              wr_en
);
   assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_en_n && !out_en_n && !vpp_hi) |-> dout_oe);

   assert_disable_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_en_n && out_en_n && !vpp_hi) |-> (!dout_oe && dout == '0));

   assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      chip_en_n |-> !dout_oe);

   assert_write_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(!prog_n) && $past(vpp_hi) && $past(out_en_n)));

   assert_verify_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_hi && !chip_en_n && !out_en_n && prog_n) |-> dout_oe);

   assert_inhibit_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_hi && chip_en_n) |-> !wr_en);

   assert_ident_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_en_n && !out_en_n && !vpp_hi && a9_hv) |->
      (dout_oe && dout == (addr[0] ? WORD_W'(16'h00F1) : WORD_W'(16'h001E))));

   assert_no_write_low_supply_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !vpp_hi |-> !wr_en);
endmodule

bind otp_word_store otp_word_store_chk #(
   .ADDR_W (ADDR_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .chip_en_n (chip_en_n),
   .out_en_n  (out_en_n),
   .prog_n    (prog_n),
   .vpp_hi    (vpp_hi),
   .a9_hv     (a9_hv),
   .addr      (addr),
   .dout      (dout),
   .dout_oe   (dout_oe),
   .wr_en     (wr_en)
);

// File: tb/otp_word_store_tb.sv
`timescale 1ns/1ps
module otp_word_store_tb;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chip_en_n = 1'b1, out_en_n = 1'b1, prog_n = 1'b1;
   logic        vpp_hi = 1'b0, a9_hv = 1'b0;
   logic [15:0] addr = '0, din = '0;
   logic [15:0] dout;
   logic        dout_oe;

   logic [15:0] shadow [DEPTH];
   int          checks = 0;
   int          fails  = 0;

   always #2 clk = ~clk;

   otp_word_store u_dut (
      .clk (clk), .rst_n (rst_n), .chip_en_n (chip_en_n), .out_en_n (out_en_n),
      .prog_n (prog_n), .vpp_hi (vpp_hi), .a9_hv (a9_hv), .addr (addr),
      .din (din), .dout (dout), .dout_oe (dout_oe)
   );

   function automatic logic [15:0] pattern(int i);
      return 16'((i * 40503) ^ 16'hC3A5);
   endfunction

   task automatic chk(string req, logic [16:0] exp);
      checks++;
      if ({dout_oe, dout} !== exp) begin
         fails++;
         $display("FAIL %s: actual oe=%0b dout=%h, expected oe=%0b dout=%h",
                  req, dout_oe, dout, exp[16], exp[15:0]);
      end
   endtask

   task automatic setup(logic ce, logic oe, logic pg, logic vpp, logic a9, logic [15:0] a);
      @(posedge clk); #1;
      chip_en_n = ce; out_en_n = oe; prog_n = pg; vpp_hi = vpp; a9_hv = a9; addr = a;
      @(negedge clk);
   endtask

   task automatic read_chk(string req, logic [15:0] a, logic [15:0] exp);
      setup(0, 0, 1, 0, 0, a);
      chk(req, {1'b1, exp});
   endtask

   task automatic prog_word(logic [15:0] a, logic [15:0] d);
      @(posedge clk); #1;
      vpp_hi = 1; chip_en_n = 0; out_en_n = 1; a9_hv = 0; addr = a; din = d; prog_n = 0;
      @(posedge clk); #1;
      prog_n = 1;
      @(posedge clk); #1;
      vpp_hi = 0; chip_en_n = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R3: standby with every other control combination
      for (int m = 0; m < 16; m++) begin
         setup(1, m[0], m[1], 0, m[2], 16'(m * 4099));
         chk("R3 standby", 17'h0);
      end

      // R4 / R1: blank array
      for (int i = 0; i < DEPTH; i++) begin
         shadow[i] = 16'hFFFF;
         read_chk("R4 blank", 16'(i), 16'hFFFF);
      end

      // R5 / R6: program every word
      for (int i = 0; i < DEPTH; i++) begin
         prog_word(16'(i), pattern(i));
         shadow[i] = shadow[i] & pattern(i);
      end
      for (int i = 0; i < DEPTH; i++) read_chk("R1 read after program R5", 16'(i), shadow[i]);

      // R7: verify mode
      for (int i = 0; i < DEPTH; i++) begin
         setup(0, 0, 1, 1, 0, 16'(i));
         chk("R7 verify", {1'b1, shadow[i]});
      end

      // R6: ones cannot come back, further zeros accumulate
      prog_word(16'd5, 16'hFFFF);
      read_chk("R6 ones kept cleared", 16'd5, shadow[5]);
      prog_word(16'd5, 16'h0F0F);
      shadow[5] = shadow[5] & 16'h0F0F;
      read_chk("R6 and-merge", 16'd5, shadow[5]);

      // R10: aliasing above DEPTH
      for (int k = 1; k < 1024; k += 97) begin
         for (int i = 0; i < DEPTH; i += 7)
            read_chk("R10 alias", 16'(i + k * DEPTH), shadow[i]);
      end
      prog_word(16'(DEPTH + 9), 16'h00FF);
      shadow[9] = shadow[9] & 16'h00FF;
      read_chk("R10 alias write", 16'd9, shadow[9]);

      // R2: output disable
      for (int m = 0; m < 4; m++) begin
         setup(0, 1, m[0], 0, m[1], 16'(m));
         chk("R2 disable", 17'h0);
      end

      // R8: inhibit with a strobe pulse
      @(posedge clk); #1;
      vpp_hi = 1; chip_en_n = 1; out_en_n = 1; addr = 16'd3; din = 16'h0000; prog_n = 0;
      @(negedge clk);
      chk("R8 inhibit quiet", 17'h0);
      @(posedge clk); #1 prog_n = 1;
      @(posedge clk); #1 vpp_hi = 0;
      read_chk("R8 inhibit kept word", 16'd3, shadow[3]);

      // R9: identification, upper address bits varied
      for (int k = 0; k < 8; k++) begin
         setup(0, 0, 1, 0, 1, 16'(k * 8194));
         chk("R9 maker id", {1'b1, 16'h001E});
         setup(0, 0, 1, 0, 1, 16'(k * 8194 + 1));
         chk("R9 device id", {1'b1, 16'h00F1});
      end

      // R11: high-supply undefined combinations stay quiet
      setup(0, 0, 0, 1, 0, 16'd7);
      chk("R11 oe and strobe low", 17'h0);
      setup(0, 1, 1, 1, 0, 16'd7);
      chk("R11 oe and strobe high", 17'h0);

      // R5: strobe rises only after output enable fell -> no write
      @(posedge clk); #1;
      vpp_hi = 1; chip_en_n = 0; out_en_n = 1; addr = 16'd11; din = 16'h0000; prog_n = 0;
      @(posedge clk); #1 out_en_n = 0;
      @(posedge clk); #1 prog_n = 1;
      @(negedge clk);
      chk("R5 verify after aborted write", {1'b1, shadow[11]});
      @(posedge clk); #1 vpp_hi = 0;
      read_chk("R5 aborted write", 16'd11, shadow[11]);

      // R12: strobe pulse with supply low
      @(posedge clk); #1;
      vpp_hi = 0; chip_en_n = 0; out_en_n = 1; addr = 16'd13; din = 16'h0000; prog_n = 0;
      @(posedge clk); #1 prog_n = 1;
      @(posedge clk);
      read_chk("R12 low supply", 16'd13, shadow[13]);

      // R4: reset restores blank
      @(posedge clk); #1 rst_n = 0;
      @(posedge clk); #1 rst_n = 1;
      read_chk("R4 blank after reset", 16'd5, 16'hFFFF);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule